// File: doc/BRIEF.md
# SDRAM Command Micro-Sequencer

This block plays back short, fixed SDRAM command routines (initialization, auto refresh, power down, wake-up) from a small writable code store. A host loads micro-words into the store and then asks for a routine to run by giving its entry address and a loop count. Once running, the sequencer executes one micro-word per clock cycle. It drives the row-strobe, column-strobe and write-enable pins from each word and follows the word's flow-control field until it reaches an end-of-routine word.

Routines that are not kept resident, such as power-down sequences, are written into the store when they are needed. A normal read or write transfer from the separate access generator may be in flight when a routine is requested. In that case the request is held in a waiting state and the routine starts only after that transfer has finished. While the sequencer is idle the pins show NOP. The auto-precharge output is never set by the sequencer.

Top module: `sdram_useq`

## Requirements
- R1: A 14-bit micro-word holds the command in bits [3:0], the flow-control field in bits [5:4] and the address argument in bits [12:6]; bit 13 is unused. Only the low ADDR_W bits of the argument are used as a store address.
- R2: Command bits [3], [2] and [1] are held active-high for RAS, CAS and WE. Each pin shows the inverse of its bit (so 1 in the word drives the pin low). The command of a word executed in cycle t appears on the pins in cycle t+1.
- R3: The `auto_pre` output is 0 at all times, whatever bit 0 of the command holds.
- R4: Whenever the sequencer did not execute a word in the previous cycle, ras_n, cas_n and we_n are all 1 (NOP).
- R5: Flow code 00 continues at the next store address.
- R6: Flow code 01 continues at the word's address argument.
- R7: Flow code 10 tests the loop counter, which is loaded from `start_loops` when the routine starts. If it is nonzero, the counter is decremented and execution continues at the address argument. If it is zero, execution continues at the next address. A loop body therefore runs start_loops+1 times.
- R8: Flow code 11 issues its own command and then returns the sequencer to idle (`seq_active` low in the following cycle).
- R9: A start request accepted while `xfer_busy` is low makes `seq_active` high on the next cycle. If `xfer_busy` is high, `seq_wait` goes high instead and the routine begins in the cycle after the first cycle in which `xfer_busy` is low.
- R10: Code-store writes are ignored while `seq_active` is high. They take effect while the sequencer is idle or waiting.
- R11: A start request is ignored while the sequencer is active or waiting. The held entry address and loop count are not replaced.
- R12: Synchronous reset makes the sequencer idle with no waiting request, and the pins show NOP from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_wr_en | input | 1 | Code-store write strobe |
| code_wr_addr | input | ADDR_W | Code-store write address |
| code_wr_data | input | 14 | Micro-word to store |
| start_req | input | 1 | Request to run a routine |
| start_addr | input | ADDR_W | Routine entry address |
| start_loops | input | CNT_W | Initial loop counter value |
| xfer_busy | input | 1 | A normal access transfer is in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| auto_pre | output | 1 | Auto-precharge line, held low |
| seq_active | output | 1 | A routine is executing |
| seq_wait | output | 1 | A routine is held until the transfer ends |

## Verification
The assertions take for granted that every routine in the store reaches an end-of-routine word. They also assume that `xfer_busy` falls within bounded time, so that the active and waiting states always drain and the flow checks see only defined store contents. The stimulus writes every address a routine can reach before it starts that routine. It drops `xfer_busy` after a few cycles, and each loop count it uses is small enough that every run ends within a handful of cycles.

// File: rtl/sdram_useq_pkg.sv
package sdram_useq_pkg;

    localparam int WORD_W = 14;
    localparam int ARG_W  = 7;

    typedef enum logic [1:0] {
        FL_NEXT = 2'b00,
        FL_JUMP = 2'b01,
        FL_LOOP = 2'b10,
        FL_END  = 2'b11
    } flow_e;

    typedef struct packed {
        logic             spare;
        logic [ARG_W-1:0] arg;
        flow_e            flow;
        logic [2:0]       rcw;   // RAS, CAS, WE, active-high
        logic             ap;    // ignored by the sequencer
    } uword_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam pins_t PINS_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic pins_t to_pins(input logic [2:0] rcw);
        return pins_t'(~rcw);
    endfunction

endpackage

// File: rtl/sdram_useq_store.sv
module sdram_useq_store
    import sdram_useq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic [ADDR_W-1:0] wr_addr,
    input  uword_t            wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output uword_t            rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    uword_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && !wr_lock) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/sdram_useq_ctrl.sv
module sdram_useq_ctrl
    import sdram_useq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_loops,
    input  logic              xfer_busy,
    input  uword_t            word,
    output logic [ADDR_W-1:0] pc,
    output logic              running,
    output logic              waiting
);
    localparam logic [ADDR_W-1:0] PC_STEP  = 1;
    localparam logic [CNT_W-1:0]  CNT_STEP = 1;

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] hold_addr;
    logic [CNT_W-1:0]  hold_loops;
    logic [ADDR_W-1:0] target;

    assign target = word.arg[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            running    <= 1'b0;
            waiting    <= 1'b0;
            pc         <= '0;
            cnt        <= '0;
            hold_addr  <= '0;
            hold_loops <= '0;
        end else if (running) begin
            unique case (word.flow)
                FL_NEXT: pc <= pc + PC_STEP;
                FL_JUMP: pc <= target;
                FL_LOOP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_STEP;
                        pc  <= target;
                    end else begin
                        pc  <= pc + PC_STEP;
                    end
                end
                FL_END:  running <= 1'b0;
                default: running <= 1'b0;
            endcase
        end else if (waiting) begin
            if (!xfer_busy) begin
                waiting <= 1'b0;
                running <= 1'b1;
                pc      <= hold_addr;
                cnt     <= hold_loops;
            end
        end else if (start_req) begin
            if (xfer_busy) begin
                waiting    <= 1'b1;
                hold_addr  <= start_addr;
                hold_loops <= start_loops;
            end else begin
                running <= 1'b1;
                pc      <= start_addr;
                cnt     <= start_loops;
            end
        end
    end

    // R5: sequential flow advances by one
    a_r5_next_step: assert property (@(posedge clk) disable iff (rst)
        (running && word.flow == FL_NEXT) |=> (running && pc == $past(pc) + PC_STEP));

    // R6: jump lands on the argument
    a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
        (running && word.flow == FL_JUMP) |=> (pc == $past(target)));

    // R7: taken loop decrements and branches
    a_r7_loop_taken: assert property (@(posedge clk) disable iff (rst)
        (running && word.flow == FL_LOOP && cnt != '0)
            |=> (cnt == $past(cnt) - CNT_STEP && pc == $past(target)));

    // R7: exhausted loop falls through
    a_r7_loop_exit: assert property (@(posedge clk) disable iff (rst)
        (running && word.flow == FL_LOOP && cnt == '0) |=> (pc == $past(pc) + PC_STEP));

    // R8: end word returns to idle
    a_r8_end_idle: assert property (@(posedge clk) disable iff (rst)
        (running && word.flow == FL_END) |=> (!running && !waiting));

    // R9: held request does not run while a transfer is busy
    a_r9_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (waiting && xfer_busy) |=> (waiting && !running));

    // R9: held request starts once the transfer ends
    a_r9_wait_release: assert property (@(posedge clk) disable iff (rst)
        (waiting && !xfer_busy) |=> (running && !waiting));

    // R11: never active and waiting at once
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({running, waiting}));

endmodule

// File: rtl/sdram_useq_pins.sv
module sdram_useq_pins
    import sdram_useq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  logic [2:0] rcw,
    output pins_t      pins
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= PINS_NOP;
        end else if (issue) begin
            pins <= to_pins(rcw);
        end else begin
            pins <= PINS_NOP;
        end
    end

endmodule

// File: rtl/sdram_useq.sv
module sdram_useq
    import sdram_useq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_wr_en,
    input  logic [ADDR_W-1:0] code_wr_addr,
    input  logic [13:0]       code_wr_data,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_loops,
    input  logic              xfer_busy,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              auto_pre,
    output logic              seq_active,
    output logic              seq_wait
);
    logic [ADDR_W-1:0] pc;
    logic              running;
    logic              waiting;
    uword_t            cur_word;
    pins_t             pins;

    sdram_useq_store #(.ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .wr_en   (code_wr_en),
        .wr_lock (running),
        .wr_addr (code_wr_addr),
        .wr_data (uword_t'(code_wr_data)),
        .rd_addr (pc),
        .rd_word (cur_word)
    );

    sdram_useq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .start_addr  (start_addr),
        .start_loops (start_loops),
        .xfer_busy   (xfer_busy),
        .word        (cur_word),
        .pc          (pc),
        .running     (running),
        .waiting     (waiting)
    );

    sdram_useq_pins pins_i (
        .clk   (clk),
        .rst   (rst),
        .issue (running),
        .rcw   (cur_word.rcw),
        .pins  (pins)
    );

    assign ras_n      = pins.ras_n;
    assign cas_n      = pins.cas_n;
    assign we_n       = pins.we_n;
    assign auto_pre   = 1'b0;
    assign seq_active = running;
    assign seq_wait   = waiting;

    // R4: idle cycle leaves NOP on the pins
    a_r4_idle_nop: assert property (@(posedge clk) disable iff (rst)
        !running |=> ({ras_n, cas_n, we_n} == 3'b111));

    // R2: executed word reaches the pins inverted, one cycle later
    a_r2_cmd_issue: assert property (@(posedge clk) disable iff (rst)
        running |=> ({ras_n, cas_n, we_n} == ~$past(cur_word.rcw)));

endmodule

// File: tb/sdram_useq_tb.sv
`timescale 1ns/1ps
module sdram_useq_tb_top;

    localparam int ADDR_W = 7;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              code_wr_en = 1'b0;
    logic [ADDR_W-1:0] code_wr_addr = '0;
    logic [13:0]       code_wr_data = '0;
    logic              start_req = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  start_loops = '0;
    logic              xfer_busy = 1'b0;
    logic              ras_n, cas_n, we_n, auto_pre, seq_active, seq_wait;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sdram_useq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .code_wr_en   (code_wr_en),
        .code_wr_addr (code_wr_addr),
        .code_wr_data (code_wr_data),
        .start_req    (start_req),
        .start_addr   (start_addr),
        .start_loops  (start_loops),
        .xfer_busy    (xfer_busy),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .auto_pre     (auto_pre),
        .seq_active   (seq_active),
        .seq_wait     (seq_wait)
    );

    // Program image: {address, word}; word = {spare, arg[6:0], flow[1:0], cmd[3:0]}
    // cmd: 1010 precharge, 1100 refresh, 1110 mode set, 1000 activate, 0000 NOP
    localparam logic [20:0] LOAD_TAB [9] = '{
        {7'h10, 1'b0, 7'h00, 2'b00, 4'b1010},
        {7'h11, 1'b0, 7'h00, 2'b00, 4'b1100},
        {7'h12, 1'b0, 7'h11, 2'b10, 4'b0001},
        {7'h13, 1'b0, 7'h20, 2'b01, 4'b1110},
        {7'h20, 1'b0, 7'h00, 2'b11, 4'b1001},
        {7'h30, 1'b0, 7'h00, 2'b11, 4'b1100},
        {7'h40, 1'b0, 7'h00, 2'b00, 4'b0000},
        {7'h41, 1'b0, 7'h00, 2'b00, 4'b0000},
        {7'h42, 1'b0, 7'h00, 2'b11, 4'b0000}
    };

    // Expected {ras_n, cas_n, we_n} for the 0x10 routine with two loop passes
    localparam logic [2:0] EXP_PINS [9] = '{
        3'b010, 3'b001, 3'b111, 3'b001, 3'b111,
        3'b001, 3'b111, 3'b000, 3'b011
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [ADDR_W-1:0] a, input logic [13:0] d);
        code_wr_en   = 1'b1;
        code_wr_addr = a;
        code_wr_data = d;
        @(negedge clk);
        code_wr_en   = 1'b0;
    endtask

    task automatic start_at(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] n);
        start_req   = 1'b1;
        start_addr  = a;
        start_loops = n;
        @(negedge clk);
        start_req   = 1'b0;
    endtask

    function automatic int pins_now();
        return {29'd0, ras_n, cas_n, we_n};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 pins", pins_now(), 3'b111);
        chk("R12 active", seq_active, 0);
        chk("R12 wait", seq_wait, 0);
        chk("R3 auto_pre", auto_pre, 0);

        for (int i = 0; i < 9; i++) write_word(LOAD_TAB[i][20:14], LOAD_TAB[i][13:0]);

        // R1 R2 R5 R6 R7 R8: main routine walked against the table
        start_at(7'h10, 8'd2);
        chk("R9 immediate start", seq_active, 1);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk($sformatf("R2 R7 seq step %0d", i), pins_now(), EXP_PINS[i]);
            chk("R3 auto_pre", auto_pre, 0);
        end
        chk("R8 idle after end", seq_active, 0);
        @(negedge clk);
        chk("R4 nop when idle", pins_now(), 3'b111);

        // R9 wait for transfer, R11 second request ignored
        xfer_busy = 1'b1;
        start_at(7'h30, 8'd0);
        chk("R9 waiting", seq_wait, 1);
        chk("R9 not active", seq_active, 0);
        start_at(7'h10, 8'd0);
        chk("R11 still waiting", seq_wait, 1);
        chk("R4 nop while waiting", pins_now(), 3'b111);
        xfer_busy = 1'b0;
        @(negedge clk);
        chk("R9 runs after release", seq_active, 1);
        @(negedge clk);
        chk("R11 held entry kept", pins_now(), 3'b001);
        chk("R8 end", seq_active, 0);

        // R10 write ignored while active, R11 start ignored while active
        start_at(7'h40, 8'd0);
        write_word(7'h42, {1'b0, 7'h00, 2'b11, 4'b1010});
        @(negedge clk);
        @(negedge clk);
        chk("R8 short routine ended", seq_active, 0);
        @(negedge clk);
        chk("R11 no restart", seq_active, 0);
        chk("R11 no wait", seq_wait, 0);
        start_at(7'h40, 8'd0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R10 locked write", pins_now(), 3'b111);
        @(negedge clk);
        write_word(7'h42, {1'b0, 7'h00, 2'b11, 4'b1010});
        start_at(7'h40, 8'd0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R10 idle write", pins_now(), 3'b010);

        // R12 reset during a routine
        @(negedge clk);
        start_at(7'h10, 8'd2);
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R12 pins after reset", pins_now(), 3'b111);
        chk("R12 idle after reset", seq_active, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 nop after reset", pins_now(), 3'b111);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule